// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Coprocessor

This block is an arithmetic helper that sits beside a small processor core. Software loads operands into a small byte-addressed register file. It then writes an operation code into the mode byte, which starts the block. Software waits until the busy flag in the status byte clears and reads the results back from the same registers. The block offers five operations: a 16x16 multiply, a 32/16 divide, a 32/32 divide, a wrapping 16x16+32 multiply-accumulate and a clamping 16x16+32 multiply-accumulate. One mode bit selects signed (two's complement) or unsigned treatment for every operation.

Each operation runs on an iterative engine and always takes the same number of cycles for a given operation. The multiplier handles four multiplier bits per cycle. The divider produces four quotient bits per cycle when the divisor is 16 bits and two bits per cycle when the divisor is 32 bits. The register file can be reached a byte, a 16-bit word, a 32-bit word or a 64-bit word at a time, in little-endian order.

Top module: `mdu_coproc`

## Requirements
- R1: After reset, bytes 0 to 9 read 0x00 and byte 15 reads 0x81.
- R2: Byte 15 always reads 0x81, and writes to it are ignored.
- R3: Bytes 10 to 14 always read 0x00, and writes to them are ignored.
- R4: `bus_size` selects 1, 2, 4 or 8 bytes (codes 0 to 3). The address is aligned down to that size. Lane k of `bus_wdata`/`bus_rdata` bits [8k+7:8k] maps to byte base+k. Read lanes beyond the size return 0.
- R5: Data registers are A = bytes 1:0, B = bytes 3:2, C = bytes 5:4 and D = bytes 7:6. Mode byte 8 holds the operation in bits [2:0] (1 multiply, 2 divide 32/16, 3 divide 32/32, 4 wrapping MAC, 5 clamping MAC) and the signed flag in bit 3, and it reads back as written. Status byte 9 holds busy in bit 0, done in bit 1 and divide-by-zero in bit 2. A write of a valid code starts the operation and clears done and divide-by-zero.
- R6: Busy stays set for exactly 4 cycles for multiply and MAC, 8 cycles for the 32/16 divide and 16 cycles for the 32/32 divide. Busy then clears and done sets.
- R7: Multiply writes A*B to C:D (C low). A and B are unchanged.
- R8: Divide takes the dividend from A:B (A low) and the divisor from C, or from C:D for the 32/32 divide. In signed mode the 16-bit divisor is sign-extended. The quotient (truncated toward zero) goes to A:B and the remainder (sign of the dividend) to C:D.
- R9: A zero divisor gives quotient 0xFFFF_FFFF, leaves the dividend in C:D as the remainder, and sets status bit 2.
- R10: The wrapping MAC writes the low 32 bits of A*B + C:D to C:D.
- R11: The clamping MAC writes 0x7FFF_FFFF when the true sum exceeds it and 0x8000_0000 when the true sum is below −2^31. Otherwise it writes the exact sum. An unsigned sum above 0x7FFF_FFFF also clamps.
- R12: While busy, every write to the register file (data, mode, status) is ignored.
- R13: While idle, a write to byte 9 sets done and divide-by-zero from bits 1 and 2. Busy cannot be written.
- R14: A mode write with an operation code of 0, 6 or 7 is stored but starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 double word, 3 quad |
| bus_addr | input | 4 | Byte address, aligned down to the access size |
| bus_wdata | input | 64 | Write data, little-endian lanes |
| bus_rdata | output | 64 | Combinational read data, little-endian lanes |

## Verification
The embedded properties assume that software reads results only after busy has cleared. They also assume that the address and size inputs carry no unknown values whenever the read port is observed. The ID and reserved-byte properties hold for any input, so they need no assumption. The stimulus polls the status byte before it reads any result. The only writes it issues during an operation are deliberate ones, made to show that they have no effect.

// File: rtl/mdu_pkg.sv
// Package: shared types and constants for the multiply/divide/MAC coprocessor.
// Assumes a 16-byte register file with 16-bit data registers.
package mdu_pkg;
    localparam int OPW      = 16;          // data register width
    localparam int ACCW     = 2 * OPW;     // product / dividend width
    localparam int NBYTES   = 16;          // register file size in bytes
    localparam int DBYTES   = 2 * ACCW / 8; // bytes that hold data registers
    localparam int MODE_IDX = 8;
    localparam int STAT_IDX = 9;
    localparam int ID_IDX   = 15;
    localparam logic [7:0] ID_VALUE = 8'h81;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_MUL   = 3'd1,
        OP_DIV16 = 3'd2,
        OP_DIV32 = 3'd3,
        OP_MAC   = 3'd4,
        OP_MACS  = 3'd5
    } op_e;

    function automatic logic op_valid(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction
endpackage

// File: rtl/mdu_mul_iter.sv
// Module: iterative unsigned shift-add multiplier, DIGIT multiplier bits per step.
// Assumes the caller asserts step for exactly W/DIGIT cycles after load and
// takes prod_nxt_o during the last step.
module mdu_mul_iter #(
    parameter int W     = 16,
    parameter int DIGIT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] prod_nxt_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] acc_q;
    logic [PW-1:0] partial;

    // Purpose: sum the shifted multiplicand for each set multiplier bit of this step.
    always_comb begin
        partial = '0;
        for (int k = 0; k < DIGIT; k++) begin
            if (mplier_q[k]) partial = partial + (mcand_q << k);
        end
        prod_nxt_o = acc_q + partial;
    end

    // Purpose: hold the running product and shift the operands one digit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= {{W{1'b0}}, mcand_i};
            mplier_q <= mplier_i;
            acc_q    <= '0;
        end else if (step) begin
            acc_q    <= prod_nxt_o;
            mcand_q  <= mcand_q << DIGIT;
            mplier_q <= mplier_q >> DIGIT;
        end
    end
endmodule

// File: rtl/mdu_div_iter.sv
// Module: iterative unsigned restoring divider. It produces MAXB quotient bits per
// step when wide_i is set, else MAXB/2. Assumes step runs W/MAXB or W/(MAXB/2)
// cycles after load. A zero divisor yields an all-ones quotient.
module mdu_div_iter #(
    parameter int W    = 32,
    parameter int MAXB = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         wide_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] quo_nxt_o,
    output logic [W-1:0] rem_nxt_o
);
    logic [W-1:0] quo_q;
    logic [W:0]   rem_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   r;
    logic [W-1:0] q;

    // Purpose: unroll up to MAXB restoring iterations for one step.
    always_comb begin
        q = quo_q;
        r = rem_q;
        for (int k = 0; k < MAXB; k++) begin
            if (wide_i || (k < MAXB / 2)) begin
                r = {r[W-1:0], q[W-1]};
                q = {q[W-2:0], 1'b0};
                if (r >= {1'b0, dvs_q}) begin
                    r    = r - {1'b0, dvs_q};
                    q[0] = 1'b1;
                end
            end
        end
        quo_nxt_o = q;
        rem_nxt_o = r[W-1:0];
    end

    // Purpose: hold partial quotient (shifting dividend) and partial remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            quo_q <= dvd_i;
            rem_q <= '0;
            dvs_q <= dvs_i;
        end else if (step) begin
            quo_q <= q;
            rem_q <= r;
        end
    end
endmodule

// File: rtl/mdu_coproc.sv
// Module: register-mapped multiply/divide/MAC coprocessor (top).
// Holds the 16-byte register file and decodes sized little-endian accesses.
// Starts an operation on a mode write and sequences the iterative engines.
// Assumes results are read only after the busy bit clears.
module mdu_coproc
    import mdu_pkg::*;
#(
    parameter int MUL_DIGIT = 4,
    parameter int DIV_MAXB  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [3:0]  bus_addr,
    input  logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata
);
    localparam int MUL_LAT   = OPW / MUL_DIGIT;
    localparam int DIV16_LAT = ACCW / DIV_MAXB;
    localparam int DIV32_LAT = ACCW / (DIV_MAXB / 2);
    localparam int CNTW      = $clog2(DIV32_LAT + 1);

    logic [7:0]      data_q [DBYTES];
    logic [7:0]      mode_q;
    logic            busy_q, done_q, err_q;
    logic            sgn_q, neg_p_q, neg_r_q, dvz_q;
    op_e             op_q;
    logic [CNTW-1:0] cnt_q;

    logic [NBYTES-1:0] sel;
    logic [7:0]        wb [NBYTES];
    logic [7:0]        rb [NBYTES];
    logic              wr_ok, start, finish;

    // Purpose: decode the sized, aligned access into byte selects and write lanes.
    always_comb begin
        int span_i, base_i;
        span_i = 1 << bus_size;
        base_i = int'(bus_addr) & ~(span_i - 1);
        for (int i = 0; i < NBYTES; i++) begin
            sel[i] = (i >= base_i) && (i < base_i + span_i);
            wb[i]  = bus_wdata[8*((i - base_i) & 7) +: 8];
        end
    end

    // Purpose: assemble the byte view of the register file and the read lanes.
    always_comb begin
        int span_i, base_i;
        for (int i = 0; i < NBYTES; i++) rb[i] = 8'h00;
        for (int i = 0; i < DBYTES; i++) rb[i] = data_q[i];
        rb[MODE_IDX] = mode_q;
        rb[STAT_IDX] = {5'b0, err_q, done_q, busy_q};
        rb[ID_IDX]   = ID_VALUE;
        span_i = 1 << bus_size;
        base_i = int'(bus_addr) & ~(span_i - 1);
        bus_rdata = '0;
        for (int k = 0; k < 8; k++) begin
            if (k < span_i) bus_rdata[8*k +: 8] = rb[(base_i + k) & (NBYTES - 1)];
        end
    end

    assign wr_ok  = bus_we && !busy_q;
    assign start  = wr_ok && sel[MODE_IDX] && op_valid(wb[MODE_IDX][2:0]);
    assign finish = busy_q && (cnt_q == CNTW'(1));

    // Operand views of the data registers.
    logic [OPW-1:0]  reg_a, reg_b, reg_c;
    logic [ACCW-1:0] reg_ab, reg_cd;
    assign reg_a  = {data_q[1], data_q[0]};
    assign reg_b  = {data_q[3], data_q[2]};
    assign reg_c  = {data_q[5], data_q[4]};
    assign reg_ab = {data_q[3], data_q[2], data_q[1], data_q[0]};
    assign reg_cd = {data_q[7], data_q[6], data_q[5], data_q[4]};

    // Start-time operand conditioning: magnitudes and result sign flags.
    op_e             new_op;
    logic            new_sgn, neg_a, neg_b, neg_n, neg_d;
    logic [OPW-1:0]  mag_a, mag_b;
    logic [ACCW-1:0] dvs_full, mag_n, mag_d;
    logic [CNTW-1:0] new_lat;

    // Purpose: derive unsigned magnitudes and latency for the operation being started.
    always_comb begin
        new_op   = op_e'(wb[MODE_IDX][2:0]);
        new_sgn  = wb[MODE_IDX][3];
        neg_a    = new_sgn && reg_a[OPW-1];
        neg_b    = new_sgn && reg_b[OPW-1];
        mag_a    = neg_a ? -reg_a : reg_a;
        mag_b    = neg_b ? -reg_b : reg_b;
        dvs_full = (new_op == OP_DIV16)
                 ? {{OPW{new_sgn && reg_c[OPW-1]}}, reg_c} : reg_cd;
        neg_n    = new_sgn && reg_ab[ACCW-1];
        neg_d    = new_sgn && dvs_full[ACCW-1];
        mag_n    = neg_n ? -reg_ab : reg_ab;
        mag_d    = neg_d ? -dvs_full : dvs_full;
        case (new_op)
            OP_DIV16: new_lat = CNTW'(DIV16_LAT);
            OP_DIV32: new_lat = CNTW'(DIV32_LAT);
            default:  new_lat = CNTW'(MUL_LAT);
        endcase
    end

    logic            is_div;
    logic [ACCW-1:0] prod_mag, quo_mag, rem_mag;
    assign is_div = (op_q == OP_DIV16) || (op_q == OP_DIV32);

    mdu_mul_iter #(.W(OPW), .DIGIT(MUL_DIGIT)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(start), .step(busy_q),
        .mcand_i(mag_a), .mplier_i(mag_b), .prod_nxt_o(prod_mag)
    );

    mdu_div_iter #(.W(ACCW), .MAXB(DIV_MAXB)) u_div (
        .clk(clk), .rst_n(rst_n), .load(start), .step(busy_q),
        .wide_i(op_q == OP_DIV16), .dvd_i(mag_n), .dvs_i(mag_d),
        .quo_nxt_o(quo_mag), .rem_nxt_o(rem_mag)
    );

    // Result shaping: sign fix, accumulate, clamp.
    logic [ACCW-1:0]        prod, quo, rem, res_ab, res_cd;
    logic signed [ACCW+1:0] sum_s;
    localparam logic signed [ACCW+1:0] SAT_HI = {3'b000, {(ACCW-1){1'b1}}};
    localparam logic signed [ACCW+1:0] SAT_LO = {3'b111, {(ACCW-1){1'b0}}};

    // Purpose: turn the engine magnitudes into the architectural results.
    always_comb begin
        prod   = neg_p_q ? -prod_mag : prod_mag;
        quo    = neg_p_q ? -quo_mag : quo_mag;
        rem    = neg_r_q ? -rem_mag : rem_mag;
        sum_s  = $signed({{2{sgn_q && prod[ACCW-1]}}, prod})
               + $signed({{2{sgn_q && reg_cd[ACCW-1]}}, reg_cd});
        res_ab = reg_ab;
        res_cd = prod;
        case (op_q)
            OP_DIV16, OP_DIV32: begin
                res_ab = dvz_q ? '1 : quo;
                res_cd = dvz_q ? reg_ab : rem;
            end
            OP_MAC:  res_cd = sum_s[ACCW-1:0];
            OP_MACS: begin
                if (sum_s > SAT_HI)      res_cd = SAT_HI[ACCW-1:0];
                else if (sum_s < SAT_LO) res_cd = SAT_LO[ACCW-1:0];
                else                     res_cd = sum_s[ACCW-1:0];
            end
            default: ;
        endcase
    end

    // Purpose: data register updates from bus writes (idle) or results (finish).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DBYTES; i++) data_q[i] <= 8'h00;
        end else if (finish) begin
            for (int i = 0; i < 4; i++) begin
                data_q[i]     <= res_ab[8*i +: 8];
                data_q[i + 4] <= res_cd[8*i +: 8];
            end
        end else if (wr_ok) begin
            for (int i = 0; i < DBYTES; i++) if (sel[i]) data_q[i] <= wb[i];
        end
    end

    // Purpose: mode/status registers and the operation sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 8'h00;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            op_q    <= OP_NONE;
            sgn_q   <= 1'b0;
            neg_p_q <= 1'b0;
            neg_r_q <= 1'b0;
            dvz_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            mode_q  <= wb[MODE_IDX];
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            op_q    <= new_op;
            sgn_q   <= new_sgn;
            neg_p_q <= ((new_op == OP_DIV16) || (new_op == OP_DIV32))
                       ? (neg_n ^ neg_d) : (neg_a ^ neg_b);
            neg_r_q <= neg_n;
            dvz_q   <= (dvs_full == '0);
            cnt_q   <= new_lat;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNTW'(1);
            if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= is_div && dvz_q;
            end
        end else if (wr_ok) begin
            if (sel[MODE_IDX]) mode_q <= wb[MODE_IDX];
            if (sel[STAT_IDX]) begin
                done_q <= wb[STAT_IDX][1];
                err_q  <= wb[STAT_IDX][2];
            end
        end
    end

    // ---------------- assertions ----------------
    logic [CNTW-1:0] chk_run;
    logic [63:0]     data_flat;
    assign data_flat = {reg_cd, reg_ab};

    // Purpose: independent count of busy cycles for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_run <= '0;
        else if (start)  chk_run <= '0;
        else if (busy_q) chk_run <= chk_run + CNTW'(1);
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> chk_run == ((op_q == OP_DIV32) ? CNTW'(DIV32_LAT) :
                                      (op_q == OP_DIV16) ? CNTW'(DIV16_LAT) :
                                                           CNTW'(MUL_LAT)));
    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));
    // R12
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(data_flat) && $stable(mode_q)));
    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size == 2'd0 && bus_addr == 4'd15) |-> bus_rdata == 64'h81);
    // R3
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_size == 2'd0 && bus_addr >= 4'd10 && bus_addr <= 4'd14) |-> bus_rdata == 64'h0);
endmodule

// File: tb/mdu_coproc_bench.sv
// Scoreboard bench: the driver computes expected results and queues them; the
// monitor pops each item and compares against what the design produces.
module mdu_coproc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [3:0]  bus_addr = 4'd0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;

    always #10 clk = ~clk;   // 50 MHz

    mdu_coproc u_mdu_coproc (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct {
        string       tag;
        int          lat;     // 0 = skip the latency check
        logic [31:0] ab;
        logic [31:0] cd;
        logic [7:0]  st;
        logic [7:0]  mode;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [3:0] ad, input logic [63:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_size = sz; bus_addr = ad; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [3:0] ad, output logic [63:0] d);
        bus_size = sz; bus_addr = ad;
        #1;
        d = bus_rdata;
    endtask

    // Reference model straight from the requirements.
    task automatic model(input logic [2:0] op, input logic sg,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] d,
                         output logic [31:0] ab, output logic [31:0] cd, output logic err);
        longint pa, pb, p, acc, s, n, dv;
        logic [31:0] abi, cdi;
        abi = {b, a}; cdi = {d, c};
        ab = abi; cd = cdi; err = 1'b0;
        pa = sg ? longint'($signed(a)) : longint'(a);
        pb = sg ? longint'($signed(b)) : longint'(b);
        p  = pa * pb;
        acc = sg ? longint'($signed(cdi)) : longint'(cdi);
        s  = p + acc;
        case (op)
            3'd1: cd = p[31:0];
            3'd4: cd = s[31:0];
            3'd5: begin
                if (s > 64'sd2147483647)       cd = 32'h7FFF_FFFF;
                else if (s < -64'sd2147483648) cd = 32'h8000_0000;
                else                           cd = s[31:0];
            end
            3'd2, 3'd3: begin
                n = sg ? longint'($signed(abi)) : longint'(abi);
                if (op == 3'd2) dv = sg ? longint'($signed(c)) : longint'(c);
                else            dv = sg ? longint'($signed(cdi)) : longint'(cdi);
                if (dv == 0) begin
                    ab = 32'hFFFF_FFFF; cd = abi; err = 1'b1;
                end else begin
                    ab = 32'(n / dv);
                    cd = 32'(n % dv);
                end
            end
            default: ;
        endcase
    endtask

    // Driver: load operands, queue the expectation, launch.
    task automatic drive_op(input string tag, input logic [2:0] op, input logic sg,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] c, input logic [15:0] d, input bit timed);
        exp_t e;
        logic err;
        model(op, sg, a, b, c, d, e.ab, e.cd, err);
        e.tag  = tag;
        e.lat  = !timed ? 0 : (op == 3'd3) ? 16 : (op == 3'd2) ? 8 : 4;
        e.st   = {5'b0, err, 1'b1, 1'b0};
        e.mode = {4'b0, sg, op};
        sbq.push_back(e);
        wr(2'd2, 4'd0, {32'h0, b, a});
        wr(2'd2, 4'd4, {32'h0, d, c});
        wr(2'd0, 4'd8, {56'h0, 4'b0, sg, op});
    endtask

    // Monitor: count busy cycles, then compare status and results.
    task automatic monitor();
        exp_t e;
        logic [63:0] v;
        int n;
        e = sbq.pop_front();
        n = 0;
        rd(2'd0, 4'd9, v);
        while (v[0] && n < 64) begin
            n++;
            @(negedge clk);
            rd(2'd0, 4'd9, v);
        end
        if (e.lat != 0) chk({e.tag, " R6 latency"}, 64'(n), 64'(e.lat));
        chk({e.tag, " R5 status"}, v, {56'h0, e.st});
        rd(2'd0, 4'd8, v);
        chk({e.tag, " R5 mode"}, v, {56'h0, e.mode});
        rd(2'd2, 4'd0, v);
        chk({e.tag, " A:B"}, v, {32'h0, e.ab});
        rd(2'd2, 4'd4, v);
        chk({e.tag, " C:D"}, v, {32'h0, e.cd});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd3, 4'd0, v);  chk("R1 bytes 0-7", v, 64'h0);
        rd(2'd3, 4'd8, v);  chk("R1 bytes 8-15", v, 64'h8100_0000_0000_0000);

        // R2 ID write ignored
        wr(2'd0, 4'd15, 64'h00);
        rd(2'd0, 4'd15, v); chk("R2 id", v, 64'h81);

        // R3 reserved bytes ignore writes (mode 0 does not start, R14)
        wr(2'd3, 4'd8, 64'hFFFF_FFFF_FFFF_0000);
        rd(2'd3, 4'd8, v);  chk("R3 reserved quad", v, 64'h8100_0000_0000_0000);
        rd(2'd0, 4'd12, v); chk("R3 reserved byte", v, 64'h0);

        // R4 sized aligned little-endian access
        wr(2'd2, 4'd5, 64'h0000_0000_DDCC_BBAA);
        rd(2'd0, 4'd6, v);  chk("R4 byte", v, 64'hCC);
        rd(2'd1, 4'd7, v);  chk("R4 word", v, 64'hDDCC);
        rd(2'd3, 4'd3, v);  chk("R4 quad", v, 64'hDDCC_BBAA_0000_0000);
        rd(2'd0, 4'd4, v);  chk("R4 upper lanes zero", v, 64'hAA);

        // R14 invalid code stored, no start
        wr(2'd0, 4'd8, 64'h07);
        @(negedge clk);
        rd(2'd0, 4'd9, v);  chk("R14 status idle", v, 64'h0);
        rd(2'd0, 4'd8, v);  chk("R14 mode stored", v, 64'h07);

        // R7 multiply
        drive_op("R7 umul max", 3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h1111, 16'h2222, 1); monitor();
        drive_op("R7 smul neg", 3'd1, 1'b1, 16'hFFFD, 16'h0007, 16'h0, 16'h0, 1); monitor();
        drive_op("R7 smul min", 3'd1, 1'b1, 16'h8000, 16'h8000, 16'h0, 16'h0, 1); monitor();

        // R8 divide
        drive_op("R8 udiv32", 3'd3, 1'b0, 16'h4240, 16'h000F, 16'h0007, 16'h0000, 1); monitor();
        drive_op("R8 sdiv32", 3'd3, 1'b1, 16'hFF9C, 16'hFFFF, 16'h0007, 16'h0000, 1); monitor();
        drive_op("R8 sdiv16 sext", 3'd2, 1'b1, 16'h0000, 16'h0001, 16'hFFF9, 16'h1234, 1); monitor();
        drive_op("R8 udiv16", 3'd2, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0003, 16'h5555, 1); monitor();

        // R9 divide by zero
        drive_op("R9 udiv32 zero", 3'd3, 1'b0, 16'h5678, 16'h1234, 16'h0000, 16'h0000, 1); monitor();
        drive_op("R9 sdiv16 zero", 3'd2, 1'b1, 16'hFF00, 16'hFFFF, 16'h0000, 16'h0005, 1); monitor();

        // R13 status writable when idle
        wr(2'd0, 4'd9, 64'h00);
        rd(2'd0, 4'd9, v);  chk("R13 status cleared", v, 64'h0);
        wr(2'd0, 4'd9, 64'h07);
        rd(2'd0, 4'd9, v);  chk("R13 status set, busy not writable", v, 64'h06);

        // R10 wrapping MAC
        drive_op("R10 umac wrap", 3'd4, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0002, 1); monitor();
        drive_op("R10 smac", 3'd4, 1'b1, 16'hFFFE, 16'h0003, 16'h000A, 16'h0000, 1); monitor();

        // R11 clamping MAC
        drive_op("R11 sat hi", 3'd5, 1'b1, 16'h7FFF, 16'h7FFF, 16'hFFFF, 16'h7FFF, 1); monitor();
        drive_op("R11 sat lo", 3'd5, 1'b1, 16'h8000, 16'h7FFF, 16'h0000, 16'h8000, 1); monitor();
        drive_op("R11 in range", 3'd5, 1'b1, 16'hFFFE, 16'h0003, 16'h0064, 16'h0000, 1); monitor();
        drive_op("R11 unsigned sat", 3'd5, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 1); monitor();

        // R12 writes during busy ignored (A and mode must keep their values)
        drive_op("R12 busy writes", 3'd3, 1'b0, 16'h0100, 16'h0000, 16'h0010, 16'h0000, 0);
        wr(2'd1, 4'd0, 64'h1234);
        wr(2'd0, 4'd8, 64'h01);
        monitor();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule